// File: doc/BRIEF.md
# Boot-Selected Memory Alias Remapper

This block chooses which physical memory responds to bus accesses that fall in an alias window starting at address zero. A 2-bit mode field decides between main flash, system flash and embedded SRAM. While reset is held, the field is loaded from a boot pin and a boot option bit. After reset, software can write the field through a single-word register port. That write replaces the boot choice until the next reset.

Every incoming bus address is checked against the window. The window covers addresses below 2^WIN_BITS. An address inside the window leaves the block with a target select and its offset within that target. An address outside the window passes through unchanged, and its select is marked as pass-through. The translation is combinational from the bus address and the registered mode. A mode write therefore reaches the route outputs only at the clock edge that captures it.

Top module: `boot_alias_remap`

## Requirements
- R1: While `rst` is high, each clock edge loads the mode from the boot inputs. Pin 0 gives mode 00, whatever the option bit. Pin 1 with option 1 gives mode 01. Pin 1 with option 0 gives mode 11.
- R2: After reset is released, changes on `boot_pin` and `boot_opt` have no effect on the mode or on the route outputs.
- R3: When the mode's bit 0 is 0 (modes 00 and 10), window accesses select main flash (`route_sel` = 0). Bit 1 is ignored in this case.
- R4: With mode 01, window accesses select system flash (`route_sel` = 1).
- R5: With mode 11, window accesses select SRAM (`route_sel` = 2).
- R6: A cycle with `reg_wr_en` high stores `reg_wr_data[1:0]` as the mode. This overrides the boot selection until a later reset reloads it from the boot inputs.
- R7: During the write cycle, the route outputs still reflect the old mode. They show the new mode from the following cycle on.
- R8: `reg_rd_data` carries the mode in bits 1:0 and zero in every higher bit. Written bits above bit 1 are ignored.
- R9: An address below 2^WIN_BITS is a window hit. For a hit, `route_hit` is 1 and `route_addr` is the offset: the low WIN_BITS address bits, zero-extended.
- R10: An address at or above 2^WIN_BITS gives `route_hit` = 0, `route_sel` = 3 (pass-through) and `route_addr` equal to `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; boot inputs are captured while high |
| boot_pin | input | 1 | Boot strap pin |
| boot_opt | input | 1 | Boot option bit from non-volatile storage |
| reg_wr_en | input | 1 | Write strobe for the mode register |
| reg_wr_data | input | DATA_W | Write data; bits 1:0 hold the mode |
| reg_rd_data | output | DATA_W | Read data; mode in bits 1:0, zero above |
| bus_addr | input | ADDR_W | Incoming bus address |
| route_hit | output | 1 | Address lies in the alias window |
| route_sel | output | 2 | 0 main flash, 1 system flash, 2 SRAM, 3 pass-through |
| route_addr | output | ADDR_W | Offset within the target for a hit, otherwise the address unchanged |

## Verification
Some properties are checked by assertions on every cycle:
- the window test and the hit-versus-pass-through outputs for the current address;
- the select that each mode value gives, including the ignored bit 1 when bit 0 is 0;
- the one-cycle latency of a write;
- the mode holding steady whenever no write is made;
- the boot-derived value present when reset falls.

Other behaviour only the bench's scenarios can show:
- that each of the four boot input combinations gives the right reset mode;
- that a later reset discards a software override;
- that toggling the boot inputs long after release leaves the routing alone;
- the exact window edges at 2^WIN_BITS-1 and 2^WIN_BITS.

// File: rtl/alias_remap_pkg.sv
package alias_remap_pkg;

    typedef logic [1:0] mode_t;

    typedef enum logic [1:0] {
        TGT_MAIN_FLASH = 2'd0,
        TGT_SYS_FLASH  = 2'd1,
        TGT_SRAM       = 2'd2,
        TGT_PASS       = 2'd3
    } tgt_e;

    typedef struct packed {
        logic hit;
        tgt_e tgt;
    } route_t;

    // Boot straps to mode: pin low -> 00, pin high + option high -> 01,
    // pin high + option low -> 11.
    function automatic mode_t boot_to_mode(input logic pin, input logic opt);
        return {pin & ~opt, pin};
    endfunction

    // Bit 0 clear means main flash regardless of bit 1.
    function automatic tgt_e mode_to_tgt(input mode_t m);
        tgt_e t;
        if (!m[0])
            t = TGT_MAIN_FLASH;
        else if (!m[1])
            t = TGT_SYS_FLASH;
        else
            t = TGT_SRAM;
        return t;
    endfunction

endpackage

// File: rtl/alias_mode_reg.sv
module alias_mode_reg
    import alias_remap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  boot_pin,
    input  logic  boot_opt,
    input  logic  wr_en,
    input  mode_t wr_mode,
    output mode_t mode_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= boot_to_mode(boot_pin, boot_opt);
        else if (wr_en)
            mode_q <= wr_mode;
    end

endmodule

// File: rtl/alias_window_decode.sv
module alias_window_decode #(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 13
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);

    generate
        if (WIN_BITS >= ADDR_W) begin : g_full
            assign hit    = 1'b1;
            assign offset = addr;
        end else begin : g_part
            localparam int HI_W = ADDR_W - WIN_BITS;
            assign hit    = (addr[ADDR_W-1:WIN_BITS] == {HI_W{1'b0}});
            assign offset = {{HI_W{1'b0}}, addr[WIN_BITS-1:0]};
        end
    endgenerate

endmodule

// File: rtl/alias_route_mux.sv
module alias_route_mux
    import alias_remap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  mode_t             mode,
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] offset,
    output route_t            route,
    output logic [ADDR_W-1:0] out_addr
);

    always_comb begin
        route.hit = hit;
        if (hit) begin
            route.tgt = mode_to_tgt(mode);
            out_addr  = offset;
        end else begin
            route.tgt = TGT_PASS;
            out_addr  = addr;
        end
    end

endmodule

// File: rtl/boot_alias_remap.sv
module boot_alias_remap
    import alias_remap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int WIN_BITS = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_pin,
    input  logic              boot_opt,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              route_hit,
    output logic [1:0]        route_sel,
    output logic [ADDR_W-1:0] route_addr
);

    localparam int PAD_W = DATA_W - 2;

    mode_t             mode_q;
    logic              win_hit;
    logic [ADDR_W-1:0] win_offset;
    route_t            route;
    logic              wr_hi_unused;

    assign wr_hi_unused = |reg_wr_data[DATA_W-1:2];

    alias_mode_reg i_mode (
        .clk      (clk),
        .rst      (rst),
        .boot_pin (boot_pin),
        .boot_opt (boot_opt),
        .wr_en    (reg_wr_en),
        .wr_mode  (reg_wr_data[1:0]),
        .mode_q   (mode_q)
    );

    alias_window_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) i_win (
        .addr   (bus_addr),
        .hit    (win_hit),
        .offset (win_offset)
    );

    alias_route_mux #(.ADDR_W(ADDR_W)) i_mux (
        .mode     (mode_q),
        .hit      (win_hit),
        .addr     (bus_addr),
        .offset   (win_offset),
        .route    (route),
        .out_addr (route_addr)
    );

    assign route_hit   = route.hit;
    assign route_sel   = route.tgt;
    assign reg_rd_data = {{PAD_W{1'b0}}, mode_q};

endmodule

// File: rtl/alias_remap_chk.sv
module alias_remap_chk
    import alias_remap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int WIN_BITS = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              boot_pin,
    input logic              boot_opt,
    input logic              reg_wr_en,
    input logic [DATA_W-1:0] reg_wr_data,
    input logic [DATA_W-1:0] reg_rd_data,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              route_hit,
    input logic [1:0]        route_sel,
    input logic [ADDR_W-1:0] route_addr
);

    logic in_win;
    assign in_win = ((bus_addr >> WIN_BITS) == '0);

    // R1
    boot_load_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> reg_rd_data[1:0] == boot_to_mode($past(boot_pin), $past(boot_opt)));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_wr_en |=> $stable(reg_rd_data));

    // R3
    main_flash_chk: assert property (@(posedge clk) disable iff (rst)
        (route_hit && !reg_rd_data[0]) |-> route_sel == 2'd0);

    // R4
    sys_flash_chk: assert property (@(posedge clk) disable iff (rst)
        (route_hit && reg_rd_data[1:0] == 2'b01) |-> route_sel == 2'd1);

    // R5
    sram_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (route_hit && reg_rd_data[1:0] == 2'b11) |-> route_sel == 2'd2);

    // R6
    sw_write_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> reg_rd_data[1:0] == $past(reg_wr_data[1:0]));

    // R8
    rd_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data >> 2) == '0);

    // R9
    win_hit_chk: assert property (@(posedge clk) disable iff (rst)
        in_win |-> (route_hit && route_addr == bus_addr));

    // R10
    pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
        !in_win |-> (!route_hit && route_sel == 2'd3 && route_addr == bus_addr));

endmodule

bind boot_alias_remap alias_remap_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS)
) i_alias_remap_chk (
    .clk         (clk),
    .rst         (rst),
    .boot_pin    (boot_pin),
    .boot_opt    (boot_opt),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .bus_addr    (bus_addr),
    .route_hit   (route_hit),
    .route_sel   (route_sel),
    .route_addr  (route_addr)
);

// File: tb/test_boot_alias_remap.sv
module test_boot_alias_remap;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int WB = 13;

    logic          clk = 1'b0;
    logic          rst, boot_pin, boot_opt, reg_wr_en;
    logic [DW-1:0] reg_wr_data, reg_rd_data;
    logic [AW-1:0] bus_addr, route_addr;
    logic          route_hit;
    logic [1:0]    route_sel;

    int         vectors = 0;
    int         miscompares = 0;
    logic [1:0] model_mode;

    always #2 clk = ~clk;

    boot_alias_remap #(.ADDR_W(AW), .DATA_W(DW), .WIN_BITS(WB)) i_boot_alias_remap (
        .clk(clk), .rst(rst), .boot_pin(boot_pin), .boot_opt(boot_opt),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .bus_addr(bus_addr), .route_hit(route_hit), .route_sel(route_sel),
        .route_addr(route_addr)
    );

    function automatic logic [1:0] exp_boot(input logic pin, input logic opt);
        if (!pin) return 2'b00;
        return opt ? 2'b01 : 2'b11;
    endfunction

    function automatic logic exp_hit(input logic [AW-1:0] a);
        return a < (AW'(1) << WB);
    endfunction

    function automatic logic [1:0] exp_sel(input logic [1:0] m, input logic [AW-1:0] a);
        if (!exp_hit(a)) return 2'd3;
        case (m)
            2'b01:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_mode(input string req);
        check({req, " rd_data"}, 64'(reg_rd_data), 64'({30'd0, model_mode}));
    endtask

    task automatic check_route(input string req);
        check({req, " hit"}, 64'(route_hit), 64'(exp_hit(bus_addr)));
        check({req, " sel"}, 64'(route_sel), 64'(exp_sel(model_mode, bus_addr)));
        check({req, " addr"}, 64'(route_addr), 64'(bus_addr));
    endtask

    task automatic do_reset(input logic pin, input logic opt);
        @(negedge clk);
        rst = 1'b1; boot_pin = pin; boot_opt = opt; reg_wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_mode = exp_boot(pin, opt);
        #1;
    endtask

    task automatic write_mode(input logic [DW-1:0] d, input string req);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = d;
        #1;
        check_mode({req, " before edge"});
        check_route({req, " before edge"});
        @(negedge clk);
        reg_wr_en = 1'b0;
        model_mode = d[1:0];
        #1;
        check_mode(req);
        check_route(req);
    endtask

    task automatic probe(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check_route(req);
    endtask

    initial begin
        #(4 * 200000);
        vectors++;
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; boot_pin = 1'b0; boot_opt = 1'b0;
        reg_wr_en = 1'b0; reg_wr_data = '0; bus_addr = 32'h100;

        // R1 R3 R4 R5: reset value from every boot combination
        for (int c = 0; c < 4; c++) begin
            do_reset(c[1], c[0]);
            check_mode("R1 reset mode");
            probe(32'h0000_0100, "R3/R4/R5 R1 boot route");
            // R2: boot inputs toggled after release are ignored
            boot_pin = ~boot_pin; boot_opt = ~boot_opt;
            repeat (3) @(negedge clk);
            #1;
            check_mode("R2 boot change ignored");
            check_route("R2 boot change ignored");
        end

        // R6 R7 R8: software override of each mode, upper bits junk
        do_reset(1'b0, 1'b0);
        bus_addr = 32'h0000_0040;
        write_mode(32'hFFFF_FFF1, "R6 R7 R8 R4 write 01");
        write_mode(32'hA5A5_A5A3, "R6 R7 R8 R5 write 11");
        write_mode(32'h1234_5672, "R6 R3 write 10");
        write_mode(32'h8000_0000, "R6 R3 write 00");
        write_mode(32'h0000_0003, "R6 write 11 again");

        // R6: a later reset discards the override
        do_reset(1'b1, 1'b1);
        check_mode("R6 reset reloads boot");

        // R9 R10: window edges
        probe(32'h0000_0000, "R9 window base");
        probe((32'd1 << WB) - 32'd1, "R9 window last");
        probe(32'd1 << WB, "R10 first outside");
        probe(32'hFFFF_FFFF, "R10 top address");
        probe(32'h2000_0010, "R10 far address");

        // Random mix of writes and accesses
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 4) == 0) begin
                write_mode($urandom(), "R6 R7 random write");
            end else begin
                logic [AW-1:0] a;
                a = $urandom();
                if ($urandom_range(0, 1) == 0) a = a & ((32'd1 << WB) - 32'd1);
                probe(a, "R9 R10 random access");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule